// File: doc/BRIEF.md
# HyperBus Command-Address Transaction Sequencer

This block sits on the controller side of an 8-bit double-data-rate flash bus. It turns a single request into one complete bus transaction. A request carries the direction, the address space, an address, up to 32 bits of write data and an access size. The block packs the direction, the space, a forced linear-burst attribute and the address into one 48-bit command-address (CA) word. There is no separate opcode. The block frames the transaction with an active-low chip select and shifts the CA word out two bytes per clock, one byte on the rising edge and one on the falling edge. It then idles the bus for a programmed latency and moves the data phase. Read data comes back as 16-bit words with a valid strobe.

The bus is modelled as two byte lanes per clock: `bus_dq_rise`/`bus_dq_fall` outbound and `bus_din_rise`/`bus_din_fall` inbound. Read data is assumed to arrive already aligned to the clock. A write-buffer mode flag makes every accepted request one self-contained halfword transaction, and it refuses any access that is not 16 bits wide. Requests are taken only while the block is idle and are ignored otherwise.

States:
- `ST_IDLE`: chip select is high.
- `ST_SETUP`: chip select is low and the bus is not driven.
- `ST_CA`: three beats.
- `ST_LAT`: latency.
- `ST_DATA`: data beats.
- `ST_HOLD`: chip select is still low and the bus is not driven.

Transitions:
- `ST_IDLE`→`ST_SETUP` on an accepted request. A rejected request stays in `ST_IDLE`.
- `ST_SETUP`→`ST_CA`.
- `ST_CA`→`ST_LAT` after the third beat when latency applies, otherwise `ST_CA`→`ST_DATA`.
- `ST_LAT`→`ST_DATA` when the latency count expires.
- `ST_DATA`→`ST_HOLD` after the last word.
- `ST_HOLD`→`ST_IDLE`.

Top module: `hb_cmd_seq`

## Requirements
- R1: The CA word is laid out as follows:
  - bit 47 = 1 for read, 0 for write.
  - bit 46 = 1 for register space, 0 for memory space.
  - bit 45 = 1 always.
  - bits 44..16 = address bits 31..3.
  - bits 15..3 = 0.
  - bits 2..0 = address bits 2..0.

  It is sent over three consecutive clocks, most significant byte first. In each clock the rise lane carries the higher byte and the fall lane the next byte, with `bus_oe` high.
- R2: Chip select framing works as follows:
  - `bus_cs_n` falls one clock before the first CA beat, and that clock has `bus_oe` low.
  - It stays low for one hold clock after the last data beat. That hold clock has `bus_oe` low and `done` high.
  - It is then high for at least one clock before the next transaction.
- R3: For reads and memory-space writes with configured latency L, the bus idles with chip select low for L−1 clocks between the CA and data phases. It idles for no clocks when L ≤ 1.
- R4: A register-space write sends its data in the clock straight after the last CA beat, whatever the latency setting.
- R5: A read produces N data clocks, where N is the burst setting and 0 counts as 1. In each data clock `rd_valid` is high and `rd_data` = {`bus_din_rise`, `bus_din_fall`}.
- R6: The write data phase depends on the access size:
  - A 32-bit write (`req_size32`=1) drives `req_wdata[31:16]` and then `req_wdata[15:0]` on two clocks.
  - A 16-bit write drives `req_wdata[15:0]` on one clock.
  - In each data clock the rise lane carries the high byte.
- R7: With `cfg_wbuf`=1, a request with `req_size32`=1 is rejected. `err` pulses for one clock after the request edge, chip select stays high and `busy` stays low.
- R8: With `cfg_wbuf`=1, each accepted 16-bit write is a complete transaction with its own setup, CA, data and hold phases. Back-to-back halfwords each get a fresh CA word.
- R9: A request presented while `busy` is high is ignored. The running transaction completes unchanged and no further transaction follows it.
- R10: After reset, `bus_cs_n`=1 and `bus_oe`, `busy`, `done`, `err` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_reg | input | 1 | 1 = register space, 0 = memory space |
| req_size32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | 32 | Write data |
| cfg_wbuf | input | 1 | Write-buffer mode |
| cfg_latency | input | LAT_W | Device latency in clocks |
| cfg_burst | input | BURST_W | Read burst length in 16-bit words (0 = 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Pulse in the chip-select hold clock |
| err | output | 1 | Rejected-request pulse |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe | output | 1 | Outbound lanes driven |
| bus_dq_rise | output | 8 | Byte sent on the rising edge |
| bus_dq_fall | output | 8 | Byte sent on the falling edge |
| bus_din_rise | input | 8 | Byte received on the rising edge |
| bus_din_fall | input | 8 | Byte received on the falling edge |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |

## Verification
Every transaction is followed clock by clock against a bench-built expectation of its frame: setup, CA beats, idle latency, data and hold.

Directed cases each separate one decision:
- Memory and register reads with a long latency show that the L−1 count applies to both.
- A register write with the same latency shows that only that combination skips the wait.
- Latencies of 0 and 1, and a zero burst, probe the boundaries of both counters.
- 32-bit versus 16-bit writes show the word order in the data phase.

In write-buffer mode, a wide request must leave the bus silent, and two consecutive halfwords must each carry a fresh CA word. A request held during the setup clock must not disturb the running frame. Random requests mix all fields so that address bits land across the whole CA word.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CA,
        ST_LAT,
        ST_DATA,
        ST_HOLD
    } hb_state_e;

    localparam int CA_W     = 48;
    localparam int CA_BEATS = 3;

    typedef struct packed {
        logic        rd;
        logic        reg_sp;
        logic        size32;
        logic [31:0] wdata;
    } hb_req_t;

endpackage

// File: rtl/hb_ca_builder.sv
module hb_ca_builder
    import hb_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                     rd,
    input  logic                     reg_sp,
    input  logic [ADDR_W-1:0]        addr,
    output logic [CA_BEATS-1:0][15:0] beats
);
    logic [31:0]     addr_ext;
    logic [CA_W-1:0] ca;

    always_comb begin
        addr_ext               = '0;
        addr_ext[ADDR_W-1:0]   = addr;
        ca                     = '0;
        ca[47]                 = rd;
        ca[46]                 = reg_sp;
        ca[45]                 = 1'b1;
        ca[44:16]              = addr_ext[31:3];
        ca[2:0]                = addr_ext[2:0];
    end

    for (genvar b = 0; b < CA_BEATS; b++) begin : g_beat
        assign beats[b] = ca[CA_W-1-16*b -: 16];
    end

endmodule

// File: rtl/hb_phase_counter.sv
module hb_phase_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/hb_cmd_seq.sv
module hb_cmd_seq
    import hb_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LAT_W   = 4,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_read,
    input  logic               req_reg,
    input  logic               req_size32,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic               cfg_wbuf,
    input  logic [LAT_W-1:0]   cfg_latency,
    input  logic [BURST_W-1:0] cfg_burst,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               bus_cs_n,
    output logic               bus_oe,
    output logic [7:0]         bus_dq_rise,
    output logic [7:0]         bus_dq_fall,
    input  logic [7:0]         bus_din_rise,
    input  logic [7:0]         bus_din_fall,
    output logic               rd_valid,
    output logic [15:0]        rd_data
);
    localparam int CNT_W = (LAT_W > BURST_W) ? ((LAT_W > 2) ? LAT_W : 2)
                                             : ((BURST_W > 2) ? BURST_W : 2);
    localparam logic [1:0] LAST_BEAT = 2'(CA_BEATS - 1);

    hb_state_e          state, nxt;
    hb_req_t            rq;
    logic [ADDR_W-1:0]  addr_q;
    logic [LAT_W-1:0]   lat_q;
    logic [BURST_W-1:0] burst_q;

    logic               accept, reject;
    logic               cnt_load;
    logic [CNT_W-1:0]   cnt_val, cnt;
    logic               cnt_last;
    logic               skip_lat;
    logic [CNT_W-1:0]   data_last;
    logic [CA_BEATS-1:0][15:0] ca_beats;
    logic [1:0]         beat_idx;
    logic [15:0]        wr_word;

    assign reject = (state == ST_IDLE) && req_valid && cfg_wbuf && req_size32;
    assign accept = (state == ST_IDLE) && req_valid && !reject;

    // Request capture and rejection pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq      <= '0;
            addr_q  <= '0;
            lat_q   <= '0;
            burst_q <= '0;
            err     <= 1'b0;
        end else begin
            err <= reject;
            if (accept) begin
                rq.rd     <= req_read;
                rq.reg_sp <= req_reg;
                rq.size32 <= req_size32;
                rq.wdata  <= req_wdata;
                addr_q    <= req_addr;
                lat_q     <= cfg_latency;
                burst_q   <= cfg_burst;
            end
        end
    end

    hb_ca_builder #(.ADDR_W(ADDR_W)) u_ca (
        .rd     (rq.rd),
        .reg_sp (rq.reg_sp),
        .addr   (addr_q),
        .beats  (ca_beats)
    );

    hb_phase_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    assign skip_lat = (rq.reg_sp && !rq.rd) || (lat_q <= LAT_W'(1));

    always_comb begin
        if (rq.rd) begin
            data_last = (burst_q == '0) ? '0 : CNT_W'(burst_q) - 1'b1;
        end else begin
            data_last = rq.size32 ? CNT_W'(1) : '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and counter loading
    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) nxt = ST_SETUP;
            end
            ST_SETUP: begin
                nxt      = ST_CA;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(CA_BEATS - 1);
            end
            ST_CA: begin
                if (cnt_last) begin
                    cnt_load = 1'b1;
                    if (skip_lat) begin
                        nxt     = ST_DATA;
                        cnt_val = data_last;
                    end else begin
                        nxt     = ST_LAT;
                        cnt_val = CNT_W'(lat_q) - CNT_W'(2);
                    end
                end
            end
            ST_LAT: begin
                if (cnt_last) begin
                    nxt      = ST_DATA;
                    cnt_load = 1'b1;
                    cnt_val  = data_last;
                end
            end
            ST_DATA: begin
                if (cnt_last) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign beat_idx = LAST_BEAT - cnt[1:0];
    assign wr_word  = (rq.size32 && cnt == CNT_W'(1)) ? rq.wdata[31:16] : rq.wdata[15:0];

    // Outputs
    always_comb begin
        busy        = 1'b1;
        done        = 1'b0;
        bus_cs_n    = 1'b0;
        bus_oe      = 1'b0;
        bus_dq_rise = '0;
        bus_dq_fall = '0;
        rd_valid    = 1'b0;
        rd_data     = '0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                bus_cs_n = 1'b1;
            end
            ST_SETUP, ST_LAT: begin
            end
            ST_CA: begin
                bus_oe      = 1'b1;
                bus_dq_rise = ca_beats[beat_idx][15:8];
                bus_dq_fall = ca_beats[beat_idx][7:0];
            end
            ST_DATA: begin
                if (rq.rd) begin
                    rd_valid = 1'b1;
                    rd_data  = {bus_din_rise, bus_din_fall};
                end else begin
                    bus_oe      = 1'b1;
                    bus_dq_rise = wr_word[15:8];
                    bus_dq_fall = wr_word[7:0];
                end
            end
            ST_HOLD: begin
                done = 1'b1;
            end
            default: begin
                busy     = 1'b0;
                bus_cs_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hb_seq_chk.sv
module hb_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_cs_n,
    input logic bus_oe,
    input logic ca_hi_bit5,
    input logic done,
    input logic err,
    input logic busy,
    input logic rd_valid
);
    // R2
    cs_setup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> !bus_oe);

    // R1
    burst_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |=> (bus_oe && ca_hi_bit5));

    // R2
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> bus_cs_n);

    // R2
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !bus_cs_n);

    // R7
    reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (bus_cs_n && !busy));

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R5
    rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!bus_cs_n && !bus_oe));

endmodule

bind hb_cmd_seq hb_seq_chk u_hb_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_oe     (bus_oe),
    .ca_hi_bit5 (bus_dq_rise[5]),
    .done       (done),
    .err        (err),
    .busy       (busy),
    .rd_valid   (rd_valid)
);

// File: tb/tb_hb_cmd_seq.sv
module tb_hb_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_read = 1'b0, req_reg = 1'b0, req_size32 = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        cfg_wbuf = 1'b0;
    logic [3:0]  cfg_latency = '0;
    logic [7:0]  cfg_burst = '0;
    logic        busy, done, err, bus_cs_n, bus_oe, rd_valid;
    logic [7:0]  bus_dq_rise, bus_dq_fall;
    logic [7:0]  din_r = '0, din_f = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hb_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_reg(req_reg), .req_size32(req_size32), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_wbuf(cfg_wbuf), .cfg_latency(cfg_latency),
        .cfg_burst(cfg_burst), .busy(busy), .done(done), .err(err),
        .bus_cs_n(bus_cs_n), .bus_oe(bus_oe), .bus_dq_rise(bus_dq_rise),
        .bus_dq_fall(bus_dq_fall), .bus_din_rise(din_r), .bus_din_fall(din_f),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_ca(input logic rd, input logic rs, input logic [31:0] a);
        return {rd, rs, 1'b1, a[31:3], 13'd0, a[2:0]};
    endfunction

    function automatic int exp_wait(input logic rd, input logic rs, input logic [3:0] l);
        if (rs && !rd) return 0;
        return (l <= 1) ? 0 : int'(l) - 1;
    endfunction

    function automatic int exp_words(input logic rd, input logic s32, input logic [7:0] b);
        if (rd) return (b == 0) ? 1 : int'(b);
        return s32 ? 2 : 1;
    endfunction

    // Called at a negedge with the block idle; returns at a negedge with it idle.
    task automatic run_txn(input logic rd, input logic rs, input logic s32,
                           input logic [31:0] a, input logic [31:0] wd,
                           input logic wb, input logic [3:0] l, input logic [7:0] b,
                           input bit poke);
        logic [47:0] ca;
        int nwait, nw;
        string ctag, ltag, dtag;
        ca    = exp_ca(rd, rs, a);
        nwait = exp_wait(rd, rs, l);
        nw    = exp_words(rd, s32, b);
        ctag  = (wb && !rd) ? "R8" : "R1";
        ltag  = (rs && !rd) ? "R4" : "R3";
        dtag  = rd ? "R5" : "R6";
        req_valid = 1'b1; req_read = rd; req_reg = rs; req_size32 = s32;
        req_addr = a; req_wdata = wd; cfg_wbuf = wb; cfg_latency = l; cfg_burst = b;
        @(posedge clk); @(negedge clk);
        if (wb && s32) begin
            chk("R7", "err pulse", 64'(err), 64'd1);
            chk("R7", "cs_n,busy", {62'd0, bus_cs_n, busy}, {62'd0, 2'b10});
            req_valid = 1'b0;
            @(negedge clk);
            chk("R7", "err,cs_n,busy after", {61'd0, err, bus_cs_n, busy}, {61'd0, 3'b010});
            return;
        end
        chk("R2", "setup cs_n,oe", {62'd0, bus_cs_n, bus_oe}, 64'd0);
        if (poke) begin
            req_addr = ~a; req_read = ~rd; req_reg = ~rs;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(ctag, "ca beat", {46'd0, bus_cs_n, bus_oe, bus_dq_rise, bus_dq_fall},
                {46'd0, 2'b01, ca[47-16*i -: 16]});
        end
        for (int i = 0; i < nwait; i++) begin
            @(negedge clk);
            chk(ltag, "latency idle", {61'd0, bus_cs_n, bus_oe, rd_valid}, 64'd0);
        end
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            if (rd) begin
                din_r = 8'($urandom); din_f = 8'($urandom);
                #1;
                chk(dtag, "read word", {46'd0, bus_cs_n, rd_valid, rd_data},
                    {46'd0, 2'b01, din_r, din_f});
            end else begin
                logic [15:0] w;
                w = (s32 && i == 0) ? wd[31:16] : wd[15:0];
                chk(dtag, "write word", {46'd0, bus_cs_n, bus_oe, bus_dq_rise, bus_dq_fall},
                    {46'd0, 2'b01, w});
            end
        end
        @(negedge clk);
        chk("R2", "hold cs_n,oe,done,rdv", {60'd0, bus_cs_n, bus_oe, done, rd_valid},
            {60'd0, 4'b0010});
        @(negedge clk);
        chk("R2", "release cs_n,busy", {62'd0, bus_cs_n, busy}, {62'd0, 2'b10});
        if (poke) begin
            @(negedge clk);
            chk("R9", "no extra frame", {62'd0, bus_cs_n, busy}, {62'd0, 2'b10});
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset outputs", {58'd0, bus_cs_n, bus_oe, busy, done, err, rd_valid},
            {58'd0, 6'b100000});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "after release", {58'd0, bus_cs_n, bus_oe, busy, done, err, rd_valid},
            {58'd0, 6'b100000});

        run_txn(1, 0, 1, 32'hA5C3_1E6F, 0, 0, 4'd6, 8'd4, 0);   // R3 memory read
        run_txn(1, 1, 1, 32'h0000_0555, 0, 0, 4'd6, 8'd2, 0);   // R3 register read
        run_txn(0, 1, 0, 32'h1234_5677, 32'hDEAD_BEEF, 0, 4'd6, 8'd1, 0); // R4
        run_txn(0, 0, 1, 32'hFFFF_FFF8, 32'hCAFE_F00D, 0, 4'd3, 8'd1, 0); // R6 wide
        run_txn(0, 0, 0, 32'h0000_0001, 32'h1111_2345, 0, 4'd2, 8'd1, 0); // R6 narrow
        run_txn(1, 0, 0, 32'h8000_0007, 0, 0, 4'd0, 8'd0, 0);   // R3/R5 boundary
        run_txn(1, 0, 0, 32'h7FFF_FFFF, 0, 0, 4'd1, 8'd3, 0);   // R3 latency 1
        run_txn(0, 0, 1, 32'h4000_0010, 32'h0BAD_0BAD, 1, 4'd5, 8'd1, 0); // R7
        run_txn(0, 0, 0, 32'h4000_0010, 32'h0000_AB12, 1, 4'd5, 8'd1, 0); // R8
        run_txn(0, 0, 0, 32'h4000_0011, 32'h0000_CD34, 1, 4'd5, 8'd1, 0); // R8
        run_txn(1, 0, 1, 32'h0246_8ACE, 0, 0, 4'd4, 8'd2, 1);   // R9 poke

        for (int n = 0; n < 60; n++) begin
            run_txn(1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom,
                    ($urandom % 4) == 0, 4'($urandom % 9), 8'($urandom % 6),
                    ($urandom % 8) == 0);
        end
        finish_run();
    end

endmodule